// File: doc/BRIEF.md
# Pulse Peak Time Interpolator

This block finds the sub-sample time of a pulse maximum in a stream of lagged derivative values, D[i] = T[i+r] - T[i], taken from a smoothed sample trace. The maximum lies where the derivative stops being positive. The block records the last valid derivative sample and its index. When a new valid sample is zero or negative, the previous one was positive, and the channel is armed, it reports one time stamp. The time stamp has an integer part, which is the index of the last positive sample, and a fraction equal to D[i0] / (D[i0] - D[i1]).

No divider is used for the fraction. Both operands are normalised so that the denominator's top bit is set. A table built at elaboration time is then indexed by the leading bits of each operand and returns the quotient, clipped just below one. After each report the block refuses further reports for a programmable number of clock cycles. One pulse therefore produces a single time stamp.

Top module: `peak_time_interp`

## Requirements
- R1: During reset and after it, `t_valid` is 0 and `t_int` and `t_frac` are 0. The first valid sample after reset has index 0.
- R2: Each sample accepted with `d_valid` = 1 gets an index equal to the number of valid samples before it since reset, modulo 2^CW. On a report, `t_int` is the index of the positive sample i0.
- R3: A report happens when all of these hold: a valid sample i1 arrives, the previous valid sample i0 has D[i0] > 0, D[i1] <= 0, `armed` is 1 in the same cycle, and the hold-off has expired. `t_valid` is then 1 for exactly the one cycle after the edge that accepted i1.
- R4: A pair of valid samples with D[i0] <= 0 or D[i1] > 0 gives no report.
- R5: A crossing presented while `armed` is 0 gives no report.
- R6: Let num = D[i0] and den = D[i0] - D[i1], both unsigned and DW+1 bits wide. Both are shifted left by the same amount until bit DW of den is 1. Take nt and dt as bits [DW:DW-LB+1] of the shifted num and den. Then `t_frac` = min(floor(nt * 2^FW / dt), 2^FW - 1). The default parameters are DW=16, LB=5 and FW=6.
- R7: When D[i1] = 0 the ratio equals one, and `t_frac` saturates to 2^FW - 1 (63 by default).
- R8: A report sets a hold-off of H = `holdoff` clock cycles, with H sampled on the reporting edge. If the report's i1 was accepted at edge e, crossings at edges e+1 through e+H are ignored. A crossing at edge e+H+1 or later is reported again.
- R9: Cycles with `d_valid` = 0 are ignored. Their `d_in` value is not used, and the bracketing pair is the last two valid samples.
- R10: The first valid sample after reset never completes a crossing, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_valid | input | 1 | Derivative sample strobe |
| d_in | input | DW | Signed lagged derivative sample |
| armed | input | 1 | Hit qualifier; the channel may report while high |
| holdoff | input | HW | Re-arm delay in clock cycles after a report |
| t_valid | output | 1 | One-cycle strobe marking a time stamp |
| t_int | output | CW | Sample index of the last positive derivative sample |
| t_frac | output | FW | Interpolated fraction toward the next sample |

## Verification
Directed sample pairs are used to separate a true positive-to-non-positive crossing from three cases that must stay silent: negative-to-positive pairs, positive-to-positive pairs, and crossings while the channel is not armed. An exact zero after a positive sample exercises the saturated fraction. An uneven pair shows whether the table indexing is right. Gaps in the strobe carrying garbage data show whether bracketing uses valid samples only. Back-to-back crossings around a hold-off of three cycles locate the exact re-arm edge. A long run of random derivative values, random strobes, random arming and varying hold-off is then compared with a bench model of the same rules.

// File: rtl/peak_time_interp.sv
module peak_time_interp #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FW = 6,
  parameter int LB = 5,
  parameter int HW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 d_valid,
  input  logic signed [DW-1:0] d_in,
  input  logic                 armed,
  input  logic [HW-1:0]        holdoff,
  output logic                 t_valid,
  output logic [CW-1:0]        t_int,
  output logic [FW-1:0]        t_frac
);
  localparam int NL   = 1 << (2*LB-1);
  localparam int SW   = $clog2(DW+2);
  localparam int FMAX = (1 << FW) - 1;

  function automatic int lut_val(input int g);
    int nt, dt, q;
    nt = g >> (LB-1);
    dt = (1 << (LB-1)) | (g & ((1 << (LB-1)) - 1));
    q  = (nt << FW) / dt;
    return (q > FMAX) ? FMAX : q;
  endfunction

  logic [FW-1:0] lut [NL];
  for (genvar g = 0; g < NL; g++) begin : g_lut
    assign lut[g] = FW'(lut_val(g));
  end

  logic [CW-1:0]        cnt, prev_idx;
  logic signed [DW-1:0] prev_d;
  logic                 prev_ok;
  logic [HW-1:0]        hold;

  logic [DW:0]   num, den, num_sh, den_sh;
  logic [SW-1:0] sh;
  logic          hit;

  assign num = {1'b0, prev_d};
  assign den = {prev_d[DW-1], prev_d} - {d_in[DW-1], d_in};

  always_comb begin
    sh = '0;
    for (int i = 0; i <= DW; i++)
      if (den[i]) sh = SW'(DW - i);
  end

  assign num_sh = num << sh;
  assign den_sh = den << sh;

  assign hit = d_valid && prev_ok && (prev_d > 0) && (d_in <= 0)
               && armed && (hold == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      prev_idx <= '0;
      prev_d   <= '0;
      prev_ok  <= 1'b0;
      hold     <= '0;
      t_valid  <= 1'b0;
      t_int    <= '0;
      t_frac   <= '0;
    end else begin
      t_valid <= hit;
      if (hit) begin
        t_int  <= prev_idx;
        t_frac <= lut[{num_sh[DW -: LB], den_sh[DW-1 -: LB-1]}];
        hold   <= holdoff;
      end else if (hold != '0) begin
        hold <= hold - 1'b1;
      end
      if (d_valid) begin
        prev_d   <= d_in;
        prev_idx <= cnt;
        prev_ok  <= 1'b1;
        cnt      <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/peak_time_interp_chk.sv
module peak_time_interp_chk #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FW = 6,
  parameter int HW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 d_valid,
  input logic signed [DW-1:0] d_in,
  input logic                 armed,
  input logic [HW-1:0]        holdoff,
  input logic                 t_valid,
  input logic [CW-1:0]        t_int,
  input logic [FW-1:0]        t_frac
);
  logic [CW-1:0] n_seen;
  logic [HW:0]   gap;
  logic [HW-1:0] rep_h;
  logic          had_rep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_seen  <= '0;
      gap     <= '0;
      rep_h   <= '0;
      had_rep <= 1'b0;
    end else begin
      if (d_valid) n_seen <= n_seen + 1'b1;
      if (t_valid) begin
        gap     <= '0;
        rep_h   <= $past(holdoff);
        had_rep <= 1'b1;
      end else if (gap != {(HW+1){1'b1}}) begin
        gap <= gap + 1'b1;
      end
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    t_valid |=> !t_valid); // R3
  AST_ON_ARMED_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    t_valid |-> $past(d_valid && armed)); // R5
  AST_NONPOS_END: assert property (@(posedge clk) disable iff (!rst_n)
    t_valid |-> $past(d_in) <= 0); // R4
  AST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    t_valid |-> t_int == n_seen - CW'(2)); // R2
  AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (t_valid && had_rep) |-> gap >= {1'b0, rep_h}); // R8
endmodule

bind peak_time_interp peak_time_interp_chk #(.DW(DW), .CW(CW), .FW(FW), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .d_valid(d_valid), .d_in(d_in), .armed(armed),
  .holdoff(holdoff), .t_valid(t_valid), .t_int(t_int), .t_frac(t_frac));

// File: tb/sim_peak_time_interp.sv
module sim_peak_time_interp;
  localparam int DW = 16, CW = 16, FW = 6, LB = 5, HW = 8;

  logic clk = 0, rst_n = 0, d_valid = 0, armed = 0;
  logic signed [DW-1:0] d_in = '0;
  logic [HW-1:0] holdoff = '0;
  logic t_valid;
  logic [CW-1:0] t_int;
  logic [FW-1:0] t_frac;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_prev = 0, m_pidx = 0, m_idx = 0, m_hold = 0;
  bit m_ok = 0;

  always #4 clk = ~clk;

  peak_time_interp #(.DW(DW), .CW(CW), .FW(FW), .LB(LB), .HW(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .d_valid(d_valid), .d_in(d_in), .armed(armed),
    .holdoff(holdoff), .t_valid(t_valid), .t_int(t_int), .t_frac(t_frac));

  function automatic int exp_frac(input int n, input int d);
    longint ns = n, ds = d;
    int nt, dt, q;
    while (ds[DW] == 1'b0) begin ns = ns << 1; ds = ds << 1; end
    nt = int'(ns >> (DW-LB+1)) & ((1 << LB) - 1);
    dt = int'(ds >> (DW-LB+1)) & ((1 << LB) - 1);
    q = (nt << FW) / dt;
    return (q > (1 << FW) - 1) ? (1 << FW) - 1 : q;
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic step(input bit v, input int d, input bit a, input string tag);
    bit ev;
    int ei, ef;
    @(negedge clk);
    d_valid = v; d_in = DW'(d); armed = a;
    ev = v && m_ok && (m_prev > 0) && (d <= 0) && a && (m_hold == 0);
    ei = m_pidx; ef = ev ? exp_frac(m_prev, m_prev - d) : 0;
    if (ev) m_hold = holdoff; else if (m_hold > 0) m_hold--;
    if (v) begin m_pidx = m_idx; m_prev = d; m_idx = (m_idx + 1) % (1 << CW); m_ok = 1; end
    @(posedge clk); #1;
    chk(tag, t_valid, ev);
    if (ev) begin
      chk({tag, " index"}, t_int, ei);
      chk({tag, " frac"}, t_frac, ef);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(posedge clk); #1;
    chk("R1 valid", t_valid, 0); chk("R1 int", t_int, 0); chk("R1 frac", t_frac, 0);
    @(negedge clk); rst_n = 1;
    step(1, -5, 1, "R10 first sample");
    step(1, 50, 1, "R2 rising");
    step(1, -10, 1, "R3 R6 crossing");
    step(1, 40, 1, "R9 setup");
    step(0, -100, 1, "R9 gap");
    step(0, 7, 1, "R9 gap");
    step(1, -40, 1, "R9 R6 half");
    step(1, -20, 1, "R4 neg");
    step(1, 30, 1, "R4 neg-to-pos");
    step(1, 31, 1, "R4 pos-to-pos");
    step(1, 20, 1, "R5 setup");
    step(1, -5, 0, "R5 disarmed");
    step(1, 100, 1, "R7 setup");
    step(1, 0, 1, "R7 saturate");
    step(1, 1234, 1, "R6 setup");
    step(1, -17, 1, "R6 uneven");
    holdoff = 3;
    step(1, 10, 1, "R8 setup");
    step(1, -1, 1, "R8 report");
    step(1, 10, 1, "R8 e+1");
    step(1, -1, 1, "R8 blocked e+2");
    step(1, 10, 1, "R8 e+3");
    step(1, -1, 1, "R8 rearmed e+4");
    for (int k = 0; k < 3000; k++) begin
      if (k % 200 == 0) holdoff = HW'($urandom_range(0, 6));
      step($urandom_range(0, 9) < 8, $urandom_range(0, 400) - 200,
           $urandom_range(0, 9) < 8, "R3 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule